// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the peripheral clock into a single-cycle enable pulse at sixteen times the serial bit rate. A serial transmitter or receiver uses the pulse as its oversampling strobe. Two stages in series set the rate. The first is a fractional prescaler. It occasionally withholds one clock cycle so that the average rate falls by the factor 1 + add/mul. The second is a 16-bit integer divider, which counts the prescaled steps.

Software configures the block through a three-entry byte register interface: the divisor low byte, the divisor high byte and a fraction register. The divisor bytes can be reached only while the divisor access input is high. A divisor change takes effect when the running period ends, so no period is ever cut short or stretched. The accumulator in the prescaler spreads the withheld cycles evenly over each group of `mul` steps.

Top module: `baud_tick_gen`

## Requirements
- R1: With no prescaling and a divisor D of 2 or more, `tick16x` is high for exactly one clock, and consecutive pulses are D clocks apart.
- R2: The divisor is the 16-bit value {high byte at address 1, low byte at address 0}. Both bytes read back on `regRdata`.
- R3: A divisor of 0x0000 divides like 0x0001, so `tick16x` is high on every clock when there is no prescaling.
- R4: While `divAccess` is 0, writes to address 0 or address 1 change nothing, and reads from those addresses return 0x00.
- R5: The fraction register sits at address 2, with mul in bits [7:4] and add in bits [3:0]. When 0 < add < mul, each run of mul prescaled steps takes mul+add clocks, with never two withheld clocks in a row. T pulses therefore span D·T·(mul+add)/mul clocks whenever mul divides D·T.
- R6: When add is 0, the prescaler passes every clock.
- R7: A mul of 0 is taken as 1. Any add that is equal to or greater than the effective mul turns the prescaler off.
- R8: A divisor write during a period does not change that period. The new value governs the period that begins at the next pulse.
- R9: The fraction register reads back whatever the value of `divAccess`. After reset the divisor is 0x0001 and the fraction register is 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divAccess | input | 1 | Divisor access bit; opens addresses 0 and 1 |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 divisor low, 1 divisor high, 2 fraction |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| tick16x | output | 1 | One-clock enable at 16x the baud rate |

## Verification
A corrupted divider count shows up at the ports within one period as a gap between pulses that is too long or too short. A pulse that lasts two clocks or more gives away a counter that reloads to zero by mistake. An accumulator that drifts, or that withholds clocks back to back, shifts the total span of a few periods away from the exact fractional figure, and this is visible after one full run of mul steps. A gating fault on the access bit is visible at once, either in the read data or in the next period length.

// File: rtl/btg_pkg.sv
`timescale 1ns/1ps
package btg_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_DIV_LO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIV_HI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FRAC   = 2'd2;

  // Strobes passed from the prescaler control to the divider datapath
  typedef struct packed {
    logic step;
  } btgStrobe_t;
endpackage

// File: rtl/btg_regs.sv
`timescale 1ns/1ps
module btg_regs
  import btg_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int FRAC_W  = 4,
  parameter int RST_DIV = 1,
  parameter int RST_MUL = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                divAccess,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic [DIV_W-1:0]    divEff,
  output logic [FRAC_W-1:0]   mulVal,
  output logic [FRAC_W-1:0]   addVal
);
  localparam int HI_W = DIV_W - DATA_W;
  localparam logic [DIV_W-1:0] RST_DIV_V = DIV_W'(RST_DIV);

  logic [DATA_W-1:0] divLo;
  logic [HI_W-1:0]   divHi;
  logic [DIV_W-1:0]  divRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLo  <= RST_DIV_V[DATA_W-1:0];
      divHi  <= RST_DIV_V[DIV_W-1:DATA_W];
      mulVal <= FRAC_W'(RST_MUL);
      addVal <= '0;
    end else if (regWe) begin
      if (divAccess && regAddr == ADDR_DIV_LO) divLo <= regWdata;
      if (divAccess && regAddr == ADDR_DIV_HI) divHi <= regWdata[HI_W-1:0];
      if (regAddr == ADDR_FRAC) begin
        mulVal <= regWdata[2*FRAC_W-1:FRAC_W];
        addVal <= regWdata[FRAC_W-1:0];
      end
    end
  end

  assign divRaw = {divHi, divLo};
  assign divEff = (divRaw == '0) ? DIV_W'(1) : divRaw;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_DIV_LO: if (divAccess) regRdata = divLo;
      ADDR_DIV_HI: if (divAccess) regRdata = DATA_W'(divHi);
      ADDR_FRAC:   regRdata = {mulVal, addVal};
      default:     regRdata = '0;
    endcase
  end

  // R4: divisor bytes are frozen while the access bit is clear
  a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !divAccess) |=> ($stable(divLo) && $stable(divHi)));
endmodule

// File: rtl/btg_ctrl.sv
`timescale 1ns/1ps
module btg_ctrl
  import btg_pkg::*;
#(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FRAC_W-1:0] mulVal,
  input  logic [FRAC_W-1:0] addVal,
  output btgStrobe_t        strb
);
  localparam int ACC_W = FRAC_W + 1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accSum;
  logic [ACC_W-1:0] mulEff;
  logic             pend;
  logic             bypass;

  assign mulEff = (mulVal == '0) ? ACC_W'(1) : {1'b0, mulVal};
  assign bypass = (addVal == '0) || ({1'b0, addVal} >= mulEff);
  assign accSum = acc + {1'b0, addVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc  <= '0;
      pend <= 1'b0;
    end else if (bypass) begin
      acc  <= '0;
      pend <= 1'b0;
    end else if (pend) begin
      pend <= 1'b0;
    end else if (acc >= mulEff) begin
      acc  <= '0;                 // stale value after a fraction change
    end else if (accSum >= mulEff) begin
      acc  <= accSum - mulEff;
      pend <= 1'b1;
    end else begin
      acc  <= accSum;
    end
  end

  assign strb.step = bypass || !pend;

  // R5: a withheld clock is always followed by a passed one
  a_r5_no_double_swallow: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> strb.step);
  // R6: zero add never withholds a clock
  a_r6_bypass_zero_add: assert property (@(posedge clk) disable iff (!rstN)
    (addVal == '0) |-> strb.step);
endmodule

// File: rtl/btg_datapath.sv
`timescale 1ns/1ps
module btg_datapath
  import btg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  btgStrobe_t       strb,
  input  logic [DIV_W-1:0] divEff,
  output logic             tick16x
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      tick16x <= 1'b0;
    end else begin
      tick16x <= 1'b0;
      if (strb.step) begin
        if (cnt == '0) begin
          cnt     <= divEff - DIV_W'(1);   // R8: reload only at terminal count
          tick16x <= 1'b1;
        end else begin
          cnt <= cnt - DIV_W'(1);
        end
      end
    end
  end

  // R1: a pulse whose reload left a nonzero count is single-cycle
  a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (tick16x && cnt != '0) |=> !tick16x);
  // R3: the divisor seen by the counter is never zero
  a_r3_nonzero_div: assert property (@(posedge clk) disable iff (!rstN)
    divEff != '0);
  // R8: the count only moves down or reloads after a pulse
  a_r8_reload_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (!tick16x && $past(cnt) != '0) |-> (cnt <= $past(cnt)));
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
  import btg_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int FRAC_W  = 4,
  parameter int RST_DIV = 1,
  parameter int RST_MUL = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        divAccess,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  output logic        tick16x
);
  logic [DIV_W-1:0]  divEff;
  logic [FRAC_W-1:0] mulVal;
  logic [FRAC_W-1:0] addVal;
  btgStrobe_t        strb;

  btg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .RST_DIV(RST_DIV), .RST_MUL(RST_MUL)) u_regs (
    .clk(clk), .rstN(rstN), .divAccess(divAccess), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .divEff(divEff), .mulVal(mulVal), .addVal(addVal)
  );

  btg_ctrl #(.FRAC_W(FRAC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mulVal(mulVal), .addVal(addVal), .strb(strb)
  );

  btg_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .divEff(divEff), .tick16x(tick16x)
  );
endmodule

// File: tb/baud_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_tick_gen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       divAccess = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       tick16x;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rstN(rstN), .divAccess(divAccess), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .tick16x(tick16x)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    regAddr = a;
    #0.5;
    v = int'(regRdata);
  endtask

  task automatic waitTick();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!tick16x && g < 2000);
  endtask

  // span in clocks covering n pulses, measured from a settled pulse
  task automatic span(input int n, output int total);
    waitTick();
    waitTick();
    total = 0;
    for (int k = 0; k < n; k++) begin
      int g = 0;
      do begin
        @(negedge clk);
        total++;
        g++;
      end while (!tick16x && g < 2000);
    end
  endtask

  task automatic setDiv(input int d);
    divAccess = 1'b1;
    wr(2'd0, 8'(d));
    wr(2'd1, 8'(d >> 8));
  endtask

  task automatic testReset();
    int v;
    check("R1 reset tick low", int'(tick16x), 0);
    divAccess = 1'b1;
    rd(2'd0, v); check("R9 reset div low", v, 1);
    rd(2'd1, v); check("R9 reset div high", v, 0);
    divAccess = 1'b0;
    rd(2'd2, v); check("R9 reset fraction", v, 8'h10);
  endtask

  task automatic testPeriodWidth();
    int t;
    setDiv(5);
    span(1, t); check("R1 period D=5", t, 5);
    @(negedge clk);
    check("R1 pulse one clock wide", int'(tick16x), 0);
  endtask

  task automatic testSixteenBit();
    int v, t;
    setDiv(16'h0103);
    rd(2'd0, v); check("R2 low byte readback", v, 8'h03);
    rd(2'd1, v); check("R2 high byte readback", v, 8'h01);
    span(1, t); check("R2 period 0x0103", t, 259);
  endtask

  task automatic testZero();
    int t;
    setDiv(0);
    span(4, t); check("R3 zero divisor span of 4", t, 4);
    @(negedge clk); check("R3 high each clock", int'(tick16x), 1);
  endtask

  task automatic testGate();
    int v, t;
    setDiv(6);
    divAccess = 1'b0;
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h01);
    rd(2'd0, v); check("R4 low read blocked", v, 0);
    rd(2'd1, v); check("R4 high read blocked", v, 0);
    span(2, t); check("R4 period unchanged", t, 12);
    divAccess = 1'b1;
    rd(2'd0, v); check("R4 low kept", v, 6);
  endtask

  task automatic testFraction();
    int t, v;
    setDiv(3);
    divAccess = 1'b0;
    wr(2'd2, 8'h31);                 // mul 3, add 1
    rd(2'd2, v); check("R9 fraction readback", v, 8'h31);
    span(3, t); check("R5 mul3 add1 D3 span", t, 12);
    setDiv(5);
    wr(2'd2, 8'h52);                 // mul 5, add 2
    span(5, t); check("R5 mul5 add2 D5 span", t, 35);
    setDiv(4);
    wr(2'd2, 8'h43);                 // mul 4, add 3
    span(4, t); check("R5 mul4 add3 D4 span", t, 28);
  endtask

  task automatic testBypass();
    int t;
    setDiv(6);
    wr(2'd2, 8'h70);                 // add 0
    span(2, t); check("R6 add zero bypass", t, 12);
    wr(2'd2, 8'h03);                 // mul 0 -> 1, add 3
    span(2, t); check("R7 mul zero bypass", t, 12);
    wr(2'd2, 8'h55);                 // add == mul
    span(2, t); check("R7 add equal mul bypass", t, 12);
  endtask

  task automatic testReload();
    int c, t;
    setDiv(10);
    wr(2'd2, 8'h10);
    waitTick();
    waitTick();
    c = 0;
    do begin
      @(negedge clk);
      c++;
      if (c == 2) begin regAddr = 2'd0; regWdata = 8'd4; regWe = 1'b1; end
      if (c == 3) regWe = 1'b0;
    end while (!tick16x && c < 2000);
    check("R8 running period keeps old divisor", c, 10);
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!tick16x && t < 2000);
    check("R8 next period uses new divisor", t, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testPeriodWidth();
    testSixteenBit();
    testZero();
    testGate();
    testFraction();
    testBypass();
    testReload();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule